// File: doc/BRIEF.md
# Clocked Serial Byte Port

This block moves one byte at a time over a three-wire synchronous link: a serial clock, a data output and a data input. Software writes a control register and a one-byte transmit holding register. The block copies the held byte into an internal shift register, then shifts it out one bit per falling serial-clock edge and samples the input on each rising edge. The port can be the clock master, with the serial clock produced by an internal divider and driven on the clock pin. It can also be a slave, following an external clock that is synchronised into the system clock domain.

Three status flags are provided: busy, shifting and holding-register-empty. An interrupt pulse tells software when the holding register has been consumed or, in receive-only mode, when a byte has been received. With an internal clock, the transfer waits for data before any clock edge is produced. Between bytes, the clock is held idle when the holding register is still empty. Clearing the start bit ends the port's activity once the byte in flight has finished.

Top module: `sio_port`

## Requirements
- R1: After reset, flag_txempty is 1, flag_busy, flag_shift and irq are 0, and sclk_out and sdo are 1.
- R2: reg_sel=0 writes the control register: bit0 start, bits 2:1 mode (00 transmit only, 01 receive only, 10 or 11 transmit and receive), bit3 order (0 MSB first, 1 LSB first), bit4 clock source (1 external). Mode, order and clock source change only while the port is idle; start can be written at any time.
- R3: A write with reg_sel=1 stores the byte in the holding register and clears flag_txempty to 0.
- R4: With the internal clock in a transmit mode, setting start while flag_txempty is 1 produces no serial clock edge and leaves flag_busy at 0.
- R5: When the holding register is copied into the shifter, flag_txempty returns to 1 in transmit modes and irq pulses for one cycle. The internal clock toggles only after this copy.
- R6: flag_busy rises after the first falling serial-clock edge following start. It stays 1 until the port stops.
- R7: sdo presents one bit per falling serial-clock edge, in the selected order. In receive-only mode sdo stays 1.
- R8: In the receive modes sdi is sampled on each rising edge. After the eighth rising edge, rx_data holds the received byte in the selected order. In receive-only mode, irq pulses at that point.
- R9: flag_shift is 1 from the first falling edge of a byte until its eighth rising edge. It is never 1 while flag_busy is 0.
- R10: When a byte ends and the holding register is empty, the internal clock stays high and flag_busy stays 1. Shifting resumes once the holding register is written.
- R11: With the external clock, the holding register is copied as soon as start is seen, without waiting for a clock edge. sclk_oe is 0, sclk_out stays 1, and shifting follows the falling and rising edges on sclk_in.
- R12: Clearing start lets the current byte finish. After that, flag_busy and flag_shift are 0 and no further byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the transmit holding register |
| reg_wdata | input | 8 | Write data |
| rx_data | output | 8 | Last received byte |
| flag_busy | output | 1 | Port active |
| flag_shift | output | 1 | Byte shift in progress |
| flag_txempty | output | 1 | Holding register empty |
| irq | output | 1 | One-cycle interrupt pulse |
| sclk_out | output | 1 | Serial clock output, idle high |
| sclk_oe | output | 1 | Clock pin drive enable (internal clock) |
| sclk_in | input | 1 | External serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The assertions assume that software changes the clock source only while the port is idle. Under that assumption the internal clock line is high whenever the port is not shifting, and the external-clock path never toggles it. They also assume that an external clock has a half-period of several system clocks, so that a falling and a rising pulse never coincide. The stimulus follows these rules in every test: configuration writes are made with start cleared, and the external clock is driven with eight system clocks per phase. sdi only changes during the low phase of the serial clock, so it is stable at every rising sample.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int CTL_START = 0;
  localparam int CTL_MODE  = 1;
  localparam int CTL_ORDER = 3;
  localparam int CTL_EXT   = 4;

  typedef enum logic [1:0] {
    MD_TX   = 2'b00,
    MD_RX   = 2'b01,
    MD_DUPA = 2'b10,
    MD_DUPB = 2'b11
  } sio_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_SHIFT = 2'b01,
    ST_HOLD  = 2'b10
  } sio_state_e;
endpackage

// File: rtl/sio_sclk_gen.sv
module sio_sclk_gen #(
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic ext_sel,
  input  logic sclk_in,
  output logic sclk_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int DIV_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0]     div_q, div_d;
  logic                 sclk_q, sclk_d;
  logic                 fall_q, fall_d, rise_q, rise_d;
  logic [SYNC_STAGES:0] sync_q, sync_d;
  logic                 run, tick, ext_fall, ext_rise;

  always_comb begin
    run      = active && !ext_sel;
    tick     = run && (div_q == DIV_W'(HALF_DIV - 1));
    div_d    = run ? (tick ? '0 : div_q + 1'b1) : '0;
    sclk_d   = run ? (tick ? ~sclk_q : sclk_q) : 1'b1;
    sync_d   = {sync_q[SYNC_STAGES-1:0], sclk_in};
    ext_fall = sync_q[SYNC_STAGES] && !sync_q[SYNC_STAGES-1];
    ext_rise = !sync_q[SYNC_STAGES] && sync_q[SYNC_STAGES-1];
    if (ext_sel) begin
      fall_d = active && ext_fall;
      rise_d = active && ext_rise;
    end else begin
      fall_d = tick && sclk_q;
      rise_d = tick && !sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      sync_q <= '1;
    end else begin
      div_q  <= div_d;
      sclk_q <= sclk_d;
      fall_q <= fall_d;
      rise_q <= rise_d;
      sync_q <= sync_d;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = fall_q;
  assign rise_o = rise_q;

  // R11
  ext_clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |-> sclk_q);
  // R4
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sclk_q);
  // R7
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_q && rise_q));
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              fall,
  input  logic              rise,
  input  logic              lsb_first,
  input  logic              drive_out,
  input  logic              sdi,
  output logic              sdo_o,
  output logic              last_o,
  output logic [DATA_W-1:0] shifted_o
);
  localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sh_q, sh_d, shifted;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sdo_q, sdo_d;
  logic              last;

  always_comb begin
    shifted = lsb_first ? {sdi, sh_q[DATA_W-1:1]} : {sh_q[DATA_W-2:0], sdi};
    last    = rise && (cnt_q == CNT_W'(DATA_W - 1));
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    sdo_d   = sdo_q;
    if (load) begin
      sh_d  = load_val;
      cnt_d = '0;
    end else if (fall) begin
      sdo_d = drive_out ? (lsb_first ? sh_q[0] : sh_q[DATA_W-1]) : 1'b1;
    end else if (rise) begin
      sh_d  = shifted;
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b1;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      sdo_q <= sdo_d;
    end
  end

  assign sdo_o     = sdo_q;
  assign last_o    = last;
  assign shifted_o = shifted;

  // R7
  sdo_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo_q));
endmodule

// File: rtl/sio_port.sv
module sio_port #(
  parameter int DATA_W      = 8,
  parameter int HALF_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rx_data,
  output logic              flag_busy,
  output logic              flag_shift,
  output logic              flag_txempty,
  output logic              irq,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sclk_in,
  output logic              sdo,
  input  logic              sdi
);
  import sio_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  sio_state_e        st_q, st_d;
  logic              start_q, start_d, lsb_q, lsb_d, ext_q, ext_d;
  sio_mode_e         mode_q, mode_d;
  logic [DATA_W-1:0] txbuf_q, txbuf_d, rx_q, rx_d;
  logic              empty_q, empty_d, busy_q, busy_d, shft_q, shft_d, irq_q, irq_d;
  logic              fall_w, rise_w, last_w, sclk_w, sdo_w;
  logic [DATA_W-1:0] shifted_w;
  logic              tx_mode, rx_mode, rx_only, have_data, load, active;

  always_comb begin
    tx_mode   = (mode_q != MD_RX);
    rx_mode   = (mode_q != MD_TX);
    rx_only   = (mode_q == MD_RX);
    have_data = rx_only || !empty_q;
    active    = (st_q == ST_SHIFT);
    load      = 1'b0;
    st_d      = st_q;
    busy_d    = busy_q;
    shft_d    = shft_q;
    rx_d      = rx_q;
    unique case (st_q)
      ST_IDLE: if (start_q && have_data) begin
        load = 1'b1;
        st_d = ST_SHIFT;
      end
      ST_SHIFT: if (last_w) begin
        if (!start_q)       st_d = ST_IDLE;
        else if (have_data) load = 1'b1;
        else                st_d = ST_HOLD;
      end
      ST_HOLD: if (!start_q) begin
        st_d = ST_IDLE;
      end else if (have_data) begin
        load = 1'b1;
        st_d = ST_SHIFT;
      end
      default: st_d = ST_IDLE;
    endcase
    if (active && fall_w) begin
      busy_d = 1'b1;
      shft_d = 1'b1;
    end
    if (last_w) begin
      shft_d = 1'b0;
      if (rx_mode) rx_d = shifted_w;
    end
    if (st_d == ST_IDLE) busy_d = 1'b0;
    irq_d = (load && tx_mode) || (last_w && rx_only);
  end

  always_comb begin
    start_d = start_q;
    mode_d  = mode_q;
    lsb_d   = lsb_q;
    ext_d   = ext_q;
    txbuf_d = txbuf_q;
    empty_d = empty_q;
    if (load && tx_mode) empty_d = 1'b1;
    if (reg_we && !reg_sel) begin
      start_d = reg_wdata[CTL_START];
      if (st_q == ST_IDLE) begin
        mode_d = sio_mode_e'(reg_wdata[CTL_MODE +: 2]);
        lsb_d  = reg_wdata[CTL_ORDER];
        ext_d  = reg_wdata[CTL_EXT];
      end
    end
    if (reg_we && reg_sel) begin
      txbuf_d = reg_wdata;
      empty_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      mode_q  <= MD_TX;
      lsb_q   <= 1'b0;
      ext_q   <= 1'b0;
      txbuf_q <= '0;
      rx_q    <= '0;
      empty_q <= 1'b1;
      busy_q  <= 1'b0;
      shft_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_d;
      mode_q  <= mode_d;
      lsb_q   <= lsb_d;
      ext_q   <= ext_d;
      txbuf_q <= txbuf_d;
      rx_q    <= rx_d;
      empty_q <= empty_d;
      busy_q  <= busy_d;
      shft_q  <= shft_d;
      irq_q   <= irq_d;
    end
  end

  sio_sclk_gen #(.HALF_DIV(HALF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_i_n), .active(active), .ext_sel(ext_q),
    .sclk_in(sclk_in), .sclk_o(sclk_w), .fall_o(fall_w), .rise_o(rise_w)
  );

  sio_shift_core #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .load(load), .load_val(txbuf_q),
    .fall(fall_w), .rise(rise_w), .lsb_first(lsb_q), .drive_out(tx_mode),
    .sdi(sdi), .sdo_o(sdo_w), .last_o(last_w), .shifted_o(shifted_w)
  );

  assign rx_data      = rx_q;
  assign flag_busy    = busy_q;
  assign flag_shift   = shft_q;
  assign flag_txempty = empty_q;
  assign irq          = irq_q;
  assign sclk_out     = sclk_w;
  assign sclk_oe      = !ext_q;
  assign sdo          = sdo_w;

  // R9
  shift_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    shft_q |-> busy_q);
  // R5
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq_q |=> !irq_q);
  // R6
  busy_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(busy_q) |-> $past(fall_w));
  // R10
  hold_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_HOLD) |-> (busy_q && sclk_w));
endmodule

// File: tb/sio_port_test.sv
module sio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       sclk_in = 1'b1;
  logic       sdi = 1'b1;
  logic [7:0] rx_data;
  logic       flag_busy, flag_shift, flag_txempty, irq, sclk_out, sclk_oe, sdo;

  int total = 0;
  int bad = 0;
  int irq_cnt = 0;

  always #2.5 clk = ~clk;

  sio_port uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rx_data(rx_data), .flag_busy(flag_busy),
    .flag_shift(flag_shift), .flag_txempty(flag_txempty), .irq(irq),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sclk_in(sclk_in),
    .sdo(sdo), .sdi(sdi)
  );

  always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  // fields: ctrl (start clear), tx byte, driven sdi byte, expected sdo byte, expected rx_data
  localparam logic [39:0] VEC [7] = '{
    {8'h00, 8'hA5, 8'h3C, 8'hA5, 8'h00},
    {8'h08, 8'h01, 8'h00, 8'h80, 8'h00},
    {8'h04, 8'hC3, 8'h5A, 8'hC3, 8'h5A},
    {8'h0C, 8'h0F, 8'h12, 8'hF0, 8'h48},
    {8'h02, 8'h00, 8'h96, 8'hFF, 8'h96},
    {8'h0A, 8'h00, 8'h01, 8'hFF, 8'h80},
    {8'h06, 8'h7E, 8'hE1, 8'h7E, 8'hE1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // master capture: drive sdi in low phase, sample sdo after each rising clock
  task automatic cap(input logic [7:0] drv, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      @(negedge sclk_out);
      @(negedge clk);
      sdi = drv[7-i];
      @(posedge sclk_out);
      @(negedge clk);
      got = {got[6:0], sdo};
      if (i == 0) chk("R6 busy after first fall", flag_busy, 1);
      if (i == 3) chk("R9 shift flag mid byte", flag_shift, 1);
    end
  endtask

  task automatic stop_later();
    @(negedge sclk_out);
    @(negedge sclk_out);
    wr(1'b0, 8'h00);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 60; k++) begin
      if (!flag_busy) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 txempty", flag_txempty, 1);
    chk("R1 busy", flag_busy, 0);
    chk("R1 shift", flag_shift, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sclk", sclk_out, 1);
    chk("R1 sdo", sdo, 1);

    // table of single-byte transfers, internal clock, stop after one byte
    for (int v = 0; v < 7; v++) begin
      logic [7:0] c, tx, dv, eg, er;
      {c, tx, dv, eg, er} = VEC[v];
      wr(1'b0, c);
      if (c[2:1] != 2'b01) wr(1'b1, tx);
      base = irq_cnt;
      wr(1'b0, c | 8'h01);
      fork
        cap(dv, got);
        stop_later();
      join
      wait_idle();
      repeat (3) @(negedge clk);
      chk($sformatf("R7 sdo order vec%0d", v), got, eg);
      chk($sformatf("R8 rx byte vec%0d", v), rx_data, er);
      chk($sformatf("R12 stopped vec%0d", v), {flag_busy, flag_shift}, 0);
      chk($sformatf("R5 one irq vec%0d", v), irq_cnt - base, 1);
      chk($sformatf("R5 txempty vec%0d", v), flag_txempty, 1);
    end

    // R4: start with empty buffer does nothing on the internal clock
    wr(1'b0, 8'h01);
    base = irq_cnt;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!sclk_out || flag_busy) break;
    end
    chk("R4 sclk idle", sclk_out, 1);
    chk("R4 not busy", flag_busy, 0);
    chk("R4 no irq", irq_cnt - base, 0);
    wr(1'b0, 8'h00);
    // R3 write clears empty flag
    wr(1'b1, 8'h5A);
    chk("R3 txempty cleared", flag_txempty, 0);
    wr(1'b0, 8'h01);
    repeat (2) @(negedge clk);
    chk("R5 load empties buffer", flag_txempty, 1);
    chk("R5 irq on load", irq_cnt - base, 1);
    chk("R6 not busy before fall", flag_busy, 0);
    cap(8'h00, got);
    chk("R7 first byte", got, 8'h5A);
    // R10 hold with no new data
    repeat (30) @(negedge clk);
    chk("R10 clock held high", sclk_out, 1);
    chk("R10 busy held", flag_busy, 1);
    chk("R9 shift flag off at boundary", flag_shift, 0);
    // R2 order change while active is ignored
    wr(1'b0, 8'h09);
    wr(1'b1, 8'h30);
    fork
      cap(8'h00, got);
      stop_later();
    join
    wait_idle();
    chk("R2 R10 resumed byte keeps MSB order", got, 8'h30);
    chk("R12 idle after stop", flag_busy, 0);

    // R11 external clock, transmit and receive
    wr(1'b0, 8'h14);
    wr(1'b1, 8'h96);
    base = irq_cnt;
    wr(1'b0, 8'h15);
    wr(1'b0, 8'h14);
    chk("R11 immediate load", flag_txempty, 1);
    chk("R11 irq on load", irq_cnt - base, 1);
    chk("R11 pin not driven", sclk_oe, 0);
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      sdi = (8'hC5 >> (7 - i)) & 1'b1;
      repeat (8) @(negedge clk);
      got = {got[6:0], sdo};
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
      if (i == 0) chk("R11 clock out stays high", sclk_out, 1);
    end
    repeat (4) @(negedge clk);
    chk("R11 sdo follows external clock", got, 8'h96);
    chk("R11 rx byte", rx_data, 8'hC5);
    chk("R12 external stop", flag_busy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule